// File: doc/BRIEF.md
# SDRAM Mode Register Programming Monitor

This block watches the command bus of a graphics DRAM from the device side. When it sees a load-mode command, it captures the address and bank-address pins into a local copy of the mode register. It then decodes that copy into the operating parameters a controller model or a checker needs: burst length, burst type, read (CAS) latency, write latency, test mode and a DLL-reset request. Whenever a stored field holds an encoding with no defined meaning, the block raises a flag.

The block also enforces the programming rules. A write is refused when any bank is open, when the reserved top bank-address bit is set, or when it comes too soon after the previous mode write. A refused write leaves the stored value untouched and raises a one-cycle error pulse. After reset the register contents have no meaning. A separate valid flag goes high only when a mode-register write is accepted after an extended-mode-register write has been accepted.

Top module: `sdram_mrs_monitor`

## Requirements
- R1: A load-mode command is recognised on a rising clock edge where cs_n_i, ras_n_i, cas_n_i and we_n_i are all 0 and cke_i is 1 at both that edge and the edge before it. Any other pin pattern has no effect on the outputs.
- R2: ba_i[1:0] = 00 targets the mode register and ba_i[1:0] = 01 targets the extended register, which only counts for ordering (R10). ba_i[1:0] = 1x is ignored and raises no error.
- R3: Burst length is taken from addr_i[1:0]: 10 gives burst_len_o = 4, 11 gives 8, and 00 or 01 give 0 (reserved). burst_seq_o is 1 when addr_i[3] = 0. addr_i[3] = 1 is reserved.
- R4: The CAS code is {addr_i[2], addr_i[6], addr_i[5], addr_i[4]}. Codes 0000 to 0011 give cas_lat_o = 8 to 11, codes 0100 to 0111 give 4 to 7, and codes 1xxx give 0 (reserved).
- R5: write_lat_o equals addr_i[11:9]. The value 0 is reserved.
- R6: test_mode_o equals the stored addr_i[7].
- R7: An accepted mode write with addr_i[8] = 1 drives dll_reset_o high for exactly the one cycle after the write edge. The stored bit then returns to 0.
- R8: After an accepted mode or extended write at edge t, a write at edges t+1 to t+TMRD-1 is refused. A write at edge t+TMRD or later is accepted. A refused write does not restart the spacing window.
- R9: A write refused because of R8, because bank_open_i is nonzero, or because ba_i[2] = 1 leaves every decoded output unchanged and drives cmd_err_o high for the one cycle after that edge.
- R10: mode_valid_o is 0 after reset. It becomes 1 after an accepted mode write that follows an accepted extended write, and then stays 1 until reset.
- R11: The fields are updated in the cycle after the write edge. rsvd_code_o is 1 whenever the stored burst length, burst type, CAS code or write latency is reserved. After reset the stored value is all zeros, so rsvd_code_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | AW (12) | Address pins |
| ba_i | input | 3 | Bank address pins |
| bank_open_i | input | NBANK (8) | One bit per bank, 1 = row open |
| burst_len_o | output | 4 | Burst length, 0 = reserved |
| burst_seq_o | output | 1 | Sequential burst type selected |
| cas_lat_o | output | 4 | Read latency in cycles, 0 = reserved |
| write_lat_o | output | 3 | Write latency in cycles, 0 = reserved |
| test_mode_o | output | 1 | Test mode selected |
| dll_reset_o | output | 1 | One-cycle DLL reset pulse |
| rsvd_code_o | output | 1 | A stored field holds a reserved code |
| cmd_err_o | output | 1 | One-cycle pulse for a refused write |
| mode_valid_o | output | 1 | Register validly programmed |

## Verification
The bench writes every one of the 4096 address patterns and checks each decoded field against arithmetic on the pattern. A design that swapped the two halves of the split CAS code, or treated it as a contiguous field, would report the wrong latency for most of the sweep. It probes the spacing window at exactly TMRD-1 and TMRD edges, then issues a retry straight after a refusal. An off-by-one counter, or one that restarts on a refused write, would accept or refuse the wrong edge. Three further groups of checks cover the remaining rules:
- A refused extended write, followed by a mode write, must leave the valid flag low.
- The DLL pulse is checked in its second cycle.
- Commands issued with CKE just risen, or with a non-load pin pattern, must change nothing.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;
  // Target selected by the two low bank-address bits
  typedef enum logic [1:0] {
    TGT_MODE = 2'b00,
    TGT_EXT  = 2'b01,
    TGT_HI2  = 2'b10,
    TGT_HI3  = 2'b11
  } mrs_target_e;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       burst_seq;
    logic [3:0] cas_lat;
    logic [2:0] write_lat;
    logic       test_mode;
    logic       rsvd;
  } mode_fields_t;
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
  import sdram_mrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_i,
  input  logic       cs_n_i,
  input  logic       ras_n_i,
  input  logic       cas_n_i,
  input  logic       we_n_i,
  input  logic [2:0] ba_i,
  output logic       mode_cmd_o,
  output logic       ext_cmd_o
);
  logic cke_q;
  logic cke_d;
  logic load_cmd;
  mrs_target_e tgt;

  always_comb begin
    cke_d = cke_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  always_comb begin
    tgt        = mrs_target_e'(ba_i[1:0]);
    load_cmd   = cke_i && cke_q && !cs_n_i && !ras_n_i && !cas_n_i && !we_n_i;
    mode_cmd_o = load_cmd && (tgt == TGT_MODE);
    ext_cmd_o  = load_cmd && (tgt == TGT_EXT);
  end
endmodule

// File: rtl/mrs_spacing_timer.sv
module mrs_spacing_timer #(
  parameter int TMRD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  generate
    if (TMRD <= 1) begin : g_none
      assign busy_o = 1'b0;
    end else begin : g_cnt
      localparam int CW = $clog2(TMRD);
      localparam logic [CW-1:0] START = CW'(TMRD - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = START;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign busy_o = (cnt_q != '0);

      assert_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
    end
  endgenerate
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import sdram_mrs_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]  mode_i,
  output mode_fields_t   fields_o
);
  logic [3:0] cas_code;
  logic       bl_bad, bt_bad, cl_bad, wl_bad;

  always_comb begin
    cas_code = {mode_i[2], mode_i[6], mode_i[5], mode_i[4]};
    bl_bad   = !mode_i[1];
    bt_bad   = mode_i[3];
    cl_bad   = cas_code[3];
    wl_bad   = (mode_i[11:9] == 3'd0);

    fields_o.burst_len = bl_bad ? 4'd0 : (mode_i[0] ? 4'd8 : 4'd4);
    fields_o.burst_seq = !bt_bad;
    if (cl_bad)           fields_o.cas_lat = 4'd0;
    else if (cas_code[2]) fields_o.cas_lat = 4'd4 + {2'b00, cas_code[1:0]};
    else                  fields_o.cas_lat = 4'd8 + {2'b00, cas_code[1:0]};
    fields_o.write_lat = mode_i[11:9];
    fields_o.test_mode = mode_i[7];
    fields_o.rsvd      = bl_bad || bt_bad || cl_bad || wl_bad;
  end

  always_comb begin
    assert_cas_range_R4: assert (fields_o.cas_lat == 4'd0 ||
      (fields_o.cas_lat >= 4'd4 && fields_o.cas_lat <= 4'd11));
    assert_rsvd_cover_R11: assert (fields_o.rsvd ||
      (fields_o.burst_len != 4'd0 && fields_o.cas_lat != 4'd0 && fields_o.write_lat != 3'd0));
  end
endmodule

// File: rtl/sdram_mrs_monitor.sv
module sdram_mrs_monitor
  import sdram_mrs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NBANK = 8,
  parameter int TMRD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             cs_n_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [2:0]       ba_i,
  input  logic [NBANK-1:0] bank_open_i,
  output logic [3:0]       burst_len_o,
  output logic             burst_seq_o,
  output logic [3:0]       cas_lat_o,
  output logic [2:0]       write_lat_o,
  output logic             test_mode_o,
  output logic             dll_reset_o,
  output logic             rsvd_code_o,
  output logic             cmd_err_o,
  output logic             mode_valid_o
);
  localparam int DLL_BIT = 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic mode_cmd, ext_cmd, busy;
  logic attempt, refuse, take_mode, take_ext, take_any;

  mrs_cmd_decode u_cmd (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cke_i      (cke_i),
    .cs_n_i     (cs_n_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .ba_i       (ba_i),
    .mode_cmd_o (mode_cmd),
    .ext_cmd_o  (ext_cmd)
  );

  mrs_spacing_timer #(.TMRD(TMRD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (take_any),
    .busy_o (busy)
  );

  always_comb begin
    attempt   = mode_cmd || ext_cmd;
    refuse    = attempt && (busy || ba_i[2] || (|bank_open_i));
    take_mode = mode_cmd && !refuse;
    take_ext  = ext_cmd && !refuse;
    take_any  = take_mode || take_ext;
  end

  // state registers with explicit next-state logic
  logic [AW-1:0] mode_q, mode_d;
  logic          dll_q, dll_d;
  logic          err_q, err_d;
  logic          ext_seen_q, ext_seen_d;
  logic          valid_q, valid_d;

  always_comb begin
    mode_d     = mode_q;
    dll_d      = 1'b0;
    err_d      = refuse;
    ext_seen_d = ext_seen_q || take_ext;
    valid_d    = valid_q;
    if (take_mode) begin
      mode_d          = addr_i;
      mode_d[DLL_BIT] = 1'b0;
      dll_d           = addr_i[DLL_BIT];
      valid_d         = valid_q || ext_seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q     <= '0;
      dll_q      <= 1'b0;
      err_q      <= 1'b0;
      ext_seen_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      dll_q      <= dll_d;
      err_q      <= err_d;
      ext_seen_q <= ext_seen_d;
      valid_q    <= valid_d;
    end
  end

  mode_fields_t fields;

  mrs_field_decode #(.AW(AW)) u_fields (
    .mode_i   (mode_q),
    .fields_o (fields)
  );

  assign burst_len_o  = fields.burst_len;
  assign burst_seq_o  = fields.burst_seq;
  assign cas_lat_o    = fields.cas_lat;
  assign write_lat_o  = fields.write_lat;
  assign test_mode_o  = fields.test_mode;
  assign rsvd_code_o  = fields.rsvd;
  assign dll_reset_o  = dll_q;
  assign cmd_err_o    = err_q;
  assign mode_valid_o = valid_q;

  assert_reject_holds_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_err_o |-> $stable(mode_q));
  assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    mode_valid_o |=> mode_valid_o);
  assert_err_no_dll_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_err_o |-> !dll_reset_o);

  generate
    if (TMRD > 1) begin : g_pulse_chk
      assert_dll_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
        dll_reset_o |=> !dll_reset_o);
    end
  endgenerate
endmodule

// File: tb/sdram_mrs_monitor_tb_top.sv
module sdram_mrs_monitor_tb_top;
  localparam int AW = 12, NBANK = 8, TMRD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [2:0] ba = '0;
  logic [NBANK-1:0] bank_open = '0;
  logic [3:0] burst_len, cas_lat;
  logic [2:0] write_lat;
  logic burst_seq, test_mode, dll_reset, rsvd_code, cmd_err, mode_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_mrs_monitor #(.AW(AW), .NBANK(NBANK), .TMRD(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .addr_i(addr), .ba_i(ba),
    .bank_open_i(bank_open), .burst_len_o(burst_len), .burst_seq_o(burst_seq),
    .cas_lat_o(cas_lat), .write_lat_o(write_lat), .test_mode_o(test_mode),
    .dll_reset_o(dll_reset), .rsvd_code_o(rsvd_code), .cmd_err_o(cmd_err),
    .mode_valid_o(mode_valid));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bl(input logic [11:0] a);
    return a[1] ? (a[0] ? 8 : 4) : 0;
  endfunction
  function automatic int exp_cl(input logic [11:0] a);
    if (a[2]) return 0;
    return (a[6] ? 4 : 8) + int'(a[5:4]);
  endfunction
  function automatic int exp_rsvd(input logic [11:0] a);
    return (!a[1] || a[3] || a[2] || a[11:9] == 3'd0) ? 1 : 0;
  endfunction

  // Checks all decoded fields against pattern a (bit 8 not stored)
  task automatic check_fields(input string req, input logic [11:0] a);
    check({req, " burst_len"}, burst_len, exp_bl(a));
    check({req, " burst_seq"}, burst_seq, a[3] ? 0 : 1);
    check({req, " cas_lat"}, cas_lat, exp_cl(a));
    check({req, " write_lat"}, write_lat, int'(a[11:9]));
    check({req, " test_mode"}, test_mode, a[7]);
    check({req, " rsvd"}, rsvd_code, exp_rsvd(a));
  endtask

  // Called at a negedge; drives for one edge, returns at the following negedge
  task automatic issue(input logic [2:0] b, input logic [11:0] a, input logic load);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = ~load; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R11 reset state
    check("R11 reset rsvd", rsvd_code, 1);
    check("R10 reset valid", mode_valid, 0);
    check("R9 reset err", cmd_err, 0);
    check("R7 reset dll", dll_reset, 0);

    // R10 ordering: mode write before any extended write
    issue(3'b000, 12'h262, 1);
    check_fields("R3 first write", 12'h262);
    check("R10 no ext yet", mode_valid, 0);
    idle(TMRD - 1);
    bank_open = 8'h10;
    issue(3'b001, 12'h000, 1);
    check("R9 ext refused bank", cmd_err, 1);
    bank_open = '0;
    idle(TMRD - 1);
    issue(3'b000, 12'h262, 1);
    check("R10 refused ext not counted", mode_valid, 0);
    idle(TMRD - 1);
    issue(3'b001, 12'h000, 1);
    check("R2 ext accepted no field change", cas_lat, exp_cl(12'h262));
    check("R10 ext alone", mode_valid, 0);
    idle(TMRD - 1);
    issue(3'b000, 12'h262, 1);
    check("R10 valid set", mode_valid, 1);
    idle(TMRD - 1);

    // R3 R4 R5 R6 R7: full sweep
    for (int v = 0; v < 4096; v++) begin
      issue(3'b000, 12'(v), 1);
      check_fields("R4 sweep", 12'(v));
      check("R7 dll pulse", dll_reset, v[8]);
      check("R9 sweep err", cmd_err, 0);
      idle(1);
      check("R7 dll cleared", dll_reset, 0);
      idle(TMRD - 2);
    end
    last = 12'hFFF;
    check("R10 sticky", mode_valid, 1);

    // R8 spacing boundary
    issue(3'b000, 12'h652, 1);
    check_fields("R8 base", 12'h652);
    idle(TMRD - 2);
    issue(3'b000, 12'h216, 1);
    check("R8 early refused err", cmd_err, 1);
    check_fields("R8 early unchanged", 12'h652);
    issue(3'b000, 12'h216, 1);
    check("R8 at TMRD accepted err", cmd_err, 0);
    check_fields("R8 at TMRD accepted", 12'h216);
    idle(1);
    check("R9 err one cycle", cmd_err, 0);
    idle(TMRD - 2);
    last = 12'h216;

    // R9 bank open and BA2
    bank_open = 8'h01;
    issue(3'b000, 12'h652, 1);
    check("R9 bank open err", cmd_err, 1);
    check_fields("R9 bank open unchanged", last);
    bank_open = '0;
    issue(3'b100, 12'h652, 1);
    check("R9 ba2 err", cmd_err, 1);
    check_fields("R9 ba2 unchanged", last);

    // R2 ba 1x ignored
    issue(3'b010, 12'h652, 1);
    check("R2 ba10 no err", cmd_err, 0);
    check_fields("R2 ba10 ignored", last);

    // R1 non-load pattern and CKE history
    issue(3'b000, 12'h652, 0);
    check("R1 non-load no err", cmd_err, 0);
    check_fields("R1 non-load ignored", last);
    cke = 0;
    idle(1);
    cke = 1;
    issue(3'b000, 12'h652, 1);
    check("R1 cke rising ignored", cmd_err, 0);
    check_fields("R1 cke rising", last);
    issue(3'b000, 12'h652, 1);
    check_fields("R1 cke stable accepted", 12'h652);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule